// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store built from flip-flops. A stack pointer always holds the address of the item currently on top. A push steps the pointer up by one and then writes the incoming word at the new address. A pop reads the word at the current address and then steps the pointer down by one. Pointer arithmetic wraps around the storage size. With the default size, the first item goes to address 1 and the last one goes to address 0.

The full and empty flags are derived from the pointer arriving at zero, so no extra count bit is needed. After an increment, a pointer of zero means the stack has just filled. After a decrement, a pointer of zero means the stack has just drained. A request that cannot be served is dropped, leaves every piece of state untouched, and raises a one-cycle error pulse. When push and pop are requested in the same cycle, only the pop is considered. Popped data appears on a registered output one cycle after the pop is accepted, and a valid strobe marks that cycle.

Top module: `reg_lifo`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is asserted and on the first cycle after it, `stk_empty` is 1 and `stk_full`, `op_err` and `rd_valid` are 0.
- R2: A push accepted while the stack is not full stores `wr_data`. `stk_empty` is 0 from the next cycle on.
- R3: `stk_full` rises on the cycle after the push that fills the last of the 2**AW entries, and not after any earlier push.
- R4: An accepted pop asserts `rd_valid` for exactly the next cycle. In that cycle `rd_data` carries the most recently pushed item that has not yet been popped (last in, first out).
- R5: `stk_empty` rises after the pop that removes the last item. Any accepted pop clears `stk_full`. The two flags are never both 1.
- R6: A push while full (with no pop requested) changes neither the flags nor the stored contents, and gives a one-cycle `op_err` pulse.
- R7: A pop while empty gives no `rd_valid`, leaves the stack empty, and gives a one-cycle `op_err` pulse.
- R8: When push and pop are requested together, only the pop is acted on and the push data is discarded. If the stack is empty, the pop is rejected as in R7 and the stack stays empty.
- R9: `op_err` is 0 in any cycle following one in which every request was accepted or none was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Request to push `wr_data` |
| pop_req | input | 1 | Request to pop the top item; wins over push |
| wr_data | input | WIDTH | Word to push |
| rd_data | output | WIDTH | Registered popped word |
| rd_valid | output | 1 | `rd_data` holds a freshly popped word |
| stk_full | output | 1 | All entries are occupied |
| stk_empty | output | 1 | No entries are occupied |
| op_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench uses the default parameters: AW of 6, which gives 64 entries, and WIDTH of 16. Filling the stack completely takes only 64 cycles at this size, so the real pointer wrap from 63 to 0 is exercised. So are the rejected push while full and a full drain back to empty. Each pushed word is distinct, so a slot that was overwritten by a rejected push, or an item popped out of order, shows up as a data mismatch in the scoreboard.

// File: rtl/reg_lifo.sv
module reg_lifo #(
  parameter int AW    = 6,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             stk_full,
  output logic             stk_empty,
  output logic             op_err
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    sp;

  wire          do_pop  = pop_req && !stk_empty;
  wire          do_push = push_req && !pop_req && !stk_full;
  wire          reject  = (pop_req && stk_empty) || (push_req && !pop_req && stk_full);
  wire [AW-1:0] sp_up   = sp + ONE;
  wire [AW-1:0] sp_dn   = sp - ONE;

  always_ff @(posedge clk) begin
    if (do_push) mem[sp_up] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= '0;
      stk_full  <= 1'b0;
      stk_empty <= 1'b1;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      op_err    <= 1'b0;
    end else begin
      rd_valid <= do_pop;
      op_err   <= reject;
      if (do_pop) begin
        rd_data   <= mem[sp];
        sp        <= sp_dn;
        stk_empty <= (sp_dn == '0);
        stk_full  <= 1'b0;
      end else if (do_push) begin
        sp        <= sp_up;
        stk_full  <= (sp_up == '0);
        stk_empty <= 1'b0;
      end
    end
  end

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(stk_full && stk_empty));
  a_r3_full_at_zero: assert property (@(posedge clk) disable iff (rst)
    stk_full |-> (sp == '0));
  a_r2_push_clears_empty: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && !stk_full) |=> !stk_empty);
  a_r4_valid_after_pop: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !stk_empty) |=> rd_valid);
  a_r6_full_push_held: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && stk_full) |=> (stk_full && op_err && sp == $past(sp)));
  a_r7_empty_pop_held: assert property (@(posedge clk) disable iff (rst)
    (pop_req && stk_empty) |=> (stk_empty && op_err && !rd_valid));
  a_r9_no_err_when_ok: assert property (@(posedge clk) disable iff (rst)
    (!(pop_req && stk_empty) && !(push_req && !pop_req && stk_full)) |=> !op_err);
endmodule

// File: tb/sim_reg_lifo.sv
module sim_reg_lifo;
  localparam int AW = 6;
  localparam int W  = 16;
  localparam int N  = 1 << AW;

  logic clk = 0, rst = 1, push_req = 0, pop_req = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, stk_full, stk_empty, op_err;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] model[$];
  logic [W-1:0] expq[$];
  bit done = 0;

  always #10 clk = ~clk;

  reg_lifo #(.AW(AW), .WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .stk_full(stk_full), .stk_empty(stk_empty), .op_err(op_err));

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(bit p, bit q, logic [W-1:0] d, string req);
    bit pop_ok, push_ok, err_e;
    @(negedge clk);
    push_req = p; pop_req = q; wr_data = d;
    pop_ok  = q && model.size() > 0;
    push_ok = p && !q && model.size() < N;
    err_e   = (q && model.size() == 0) || (p && !q && model.size() == N);
    if (pop_ok) expq.push_back(model.pop_back());
    else if (push_ok) model.push_back(d);
    @(posedge clk); #5;
    chk(stk_full == (model.size() == N), {req, " full"}, stk_full, model.size() == N);
    chk(stk_empty == (model.size() == 0), {req, " empty"}, stk_empty, model.size() == 0);
    chk(op_err == err_e, {req, " err"}, op_err, err_e);
    push_req = 0; pop_req = 0;
  endtask

  // Monitor: R4 data order and valid strobe
  initial forever begin
    @(posedge clk); #6;
    if (!rst) begin
      if (rd_valid) begin
        if (expq.size() == 0) chk(0, "R4 unexpected valid", 1, 0);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          chk(rd_data == e, "R4 pop data", rd_data, e);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(stk_empty == 1 && stk_full == 0 && op_err == 0 && rd_valid == 0, "R1 in reset",
        {stk_empty, stk_full, op_err, rd_valid}, 4'b1000);
    @(negedge clk); rst = 0;
    @(posedge clk); #5;
    chk(stk_empty == 1 && stk_full == 0 && op_err == 0 && rd_valid == 0, "R1 after reset",
        {stk_empty, stk_full, op_err, rd_valid}, 4'b1000);

    op(0, 1, '0, "R7 pop empty");
    op(0, 0, '0, "R9 idle after error");
    chk(rd_valid == 0, "R7 no valid", rd_valid, 0);

    op(1, 0, 16'hA001, "R2 push");
    op(1, 0, 16'hA002, "R2 push");
    op(1, 0, 16'hA003, "R2 push");
    op(0, 1, '0, "R4 pop");
    op(0, 1, '0, "R4 pop");
    op(0, 1, '0, "R5 pop last");

    for (int i = 0; i < N; i++) op(1, 0, 16'h1000 + W'(i), "R3 fill");
    op(1, 0, 16'hDEAD, "R6 push full");
    op(1, 0, 16'hBEEF, "R6 push full again");
    op(1, 1, 16'hCAFE, "R8 both while full");
    op(1, 0, 16'h2222, "R2 refill");
    for (int i = 0; i < N; i++) op(0, 1, '0, "R5 drain");
    op(1, 1, 16'h7777, "R8 both while empty");
    op(0, 0, '0, "R8 idle");

    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 2) op(0, 1, '0, "R4 mixed pop");
      else op(1, 0, 16'h5000 + W'(i), "R2 mixed push");
    end
    while (model.size() > 0) op(0, 1, '0, "R5 final drain");
    op(0, 0, '0, "R9 idle");
    repeat (2) @(posedge clk);
    #7;
    chk(expq.size() == 0, "R4 all pops returned", expq.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule